// File: doc/BRIEF.md
# Read Output Stage with Flow-Through or Registered Data

This block sits between the read port of a synchronous memory array and the data bus. Each clock edge captures a 2-bit command into an input register. The array returns data for a captured read during the cycle that follows. A static mode pin selects one of two timings. In flow-through timing, that array data goes straight to the bus. In registered timing, an output register takes the data on the next rising edge, which costs one more cycle.

The block tracks which stage holds a live read beat and raises the bus enable only for such a beat. A deselect turns the bus off early. It acts from the input register, so in registered timing the bus goes quiet right after the last read beat, with no extra trailing stage. An active-low output-enable gates the bus drivers with no clock involved. The surrounding logic builds the tri-state bus as `dq_en ? dq_o : 'z`.

Top module: `rdo_read_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dq_en` is low.
- R2: With `pipe_mode` = 0, after the edge that captures a read (command 2'b01), `dq_o` follows `arr_rdata` combinationally and `dq_en` is high until the next capture edge.
- R3: With `pipe_mode` = 1, the `arr_rdata` value presented in the cycle after the edge that captures a read appears on `dq_o` from the following edge, one cycle later than in R2, and `dq_en` is high for that cycle.
- R4: A deselect (command 2'b00) clears the read beat when it is captured. In flow-through timing the bus is off right after the capture edge. In registered timing it is off right after the next edge.
- R5: A write (command 2'b10) never causes the bus to be driven, and it clears any live read beat in the same way as a deselect.
- R6: A hold (command 2'b11) keeps the current read-beat state. While a read is held, the bus keeps presenting the array data for each cycle at the timing of the selected mode.
- R7: `oe_n` high forces `dq_en` low and `oe_n` low restores it, within a clock period and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through; change only under reset |
| cmd | input | 2 | 00 deselect, 01 read, 10 write, 11 hold |
| arr_rdata | input | DATA_W | Array read data for the command captured at the last edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_o | output | DATA_W | Data toward the bus drivers |
| dq_en | output | 1 | Bus driver enable |

## Verification
In flow-through timing, the bus result of a command captured at edge k is due in the cycle after edge k. In registered timing it is due after edge k+1. A deselect or write turns the bus off at that same point. The reference model keeps a history of each captured command and each array value by edge index. At every falling edge it compares the outputs against the entry one or two edges back, after a hold walks back to the last command that set the state. The output-enable is also toggled between edges and checked with no clock in between, which shows that it acts without a clock.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_HOLD  = 2'b11
  } rdo_cmd_e;

  // next read-beat state after a command is captured
  function automatic logic rdo_next_beat(rdo_cmd_e c, logic cur);
    case (c)
      CMD_READ: return 1'b1;
      CMD_HOLD: return cur;
      default:  return 1'b0;
    endcase
  endfunction

  // bus drive decision: live beat and enable asserted (active low)
  function automatic logic rdo_drive(logic beat, logic oe_n);
    return beat & ~oe_n;
  endfunction

endpackage

// File: rtl/rdo_cmd_stage.sv
module rdo_cmd_stage
  import rdo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rdo_cmd_e cmd_i,
  output logic     beat_o,
  output logic     desel_o,
  output logic     wr_o
);

  rdo_cmd_e cmd_q;
  logic     beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      beat_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_i;
      beat_q <= rdo_next_beat(cmd_i, beat_q);
    end
  end

  assign beat_o  = beat_q;
  assign desel_o = (cmd_q == CMD_DESEL);
  assign wr_o    = (cmd_q == CMD_WRITE);

endmodule

// File: rtl/rdo_out_reg.sv
module rdo_out_reg #(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              beat_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int LANES = DATA_W / LANE_W;

  logic beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= 1'b0;
    else        beat_q <= beat_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q <= '0;
      else if (beat_i) lane_q <= data_i[l*LANE_W +: LANE_W];
    end
    assign data_o[l*LANE_W +: LANE_W] = lane_q;
  end

  assign beat_o = beat_q;

endmodule

// File: rtl/rdo_bus_gate.sv
module rdo_bus_gate
  import rdo_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              flow_beat,
  input  logic [DATA_W-1:0] flow_data,
  input  logic              reg_beat,
  input  logic [DATA_W-1:0] reg_data,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en
);

  logic beat_sel;

  always_comb begin
    beat_sel = pipe_mode ? reg_beat : flow_beat;
    dq_o     = pipe_mode ? reg_data : flow_data;
    dq_en    = rdo_drive(beat_sel, oe_n);
  end

endmodule

// File: rtl/rdo_read_stage.sv
module rdo_read_stage
  import rdo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en
);

  // named internal events for the checker
  logic              rd_cap;
  logic              desel_cap;
  logic              wr_cap;
  logic              reg_beat;
  logic [DATA_W-1:0] reg_data;

  rdo_cmd_stage u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (rdo_cmd_e'(cmd)),
    .beat_o  (rd_cap),
    .desel_o (desel_cap),
    .wr_o    (wr_cap)
  );

  rdo_out_reg #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat_i (rd_cap),
    .data_i (arr_rdata),
    .beat_o (reg_beat),
    .data_o (reg_data)
  );

  rdo_bus_gate #(.DATA_W(DATA_W)) u_gate (
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .flow_beat (rd_cap),
    .flow_data (arr_rdata),
    .reg_beat  (reg_beat),
    .reg_data  (reg_data),
    .dq_o      (dq_o),
    .dq_en     (dq_en)
  );

endmodule

// File: rtl/rdo_read_stage_chk.sv
module rdo_read_stage_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              oe_n,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_en,
  input logic              rd_cap,
  input logic              desel_cap,
  input logic              wr_cap
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !dq_en);

  p_flow_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_cap) |-> dq_o == arr_rdata);

  p_reg_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_cap) |=> dq_o == $past(arr_rdata));

  p_flow_desel_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && desel_cap) |-> !dq_en);

  p_reg_desel_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && desel_cap) |=> !dq_en);

  p_reg_write_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && wr_cap) |=> !dq_en);

  p_flow_write_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && wr_cap) |-> !dq_en);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);

endmodule

bind rdo_read_stage rdo_read_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .oe_n      (oe_n),
  .arr_rdata (arr_rdata),
  .dq_o      (dq_o),
  .dq_en     (dq_en),
  .rd_cap    (rd_cap),
  .desel_cap (desel_cap),
  .wr_cap    (wr_cap)
);

// File: tb/tb_rdo_read_stage.sv
`timescale 1ns/100ps
module tb_rdo_read_stage;

  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_mode = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic [W-1:0] arr_rdata = '0;
  logic         oe_n = 1'b0;
  logic [W-1:0] dq_o;
  logic         dq_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdo_read_stage #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cmd(cmd),
    .arr_rdata(arr_rdata), .oe_n(oe_n), .dq_o(dq_o), .dq_en(dq_en)
  );

  // reference history: command captured at each edge since reset,
  // array value seen during the cycle after each edge
  logic [1:0]   capcmd [0:4095];
  logic [W-1:0] arrval [0:4095];
  int ncap = 0;

  always @(posedge clk) begin
    if (!rst_n) ncap = 0;
    else begin
      if (ncap > 0) arrval[ncap-1] = arr_rdata;
      capcmd[ncap] = cmd;
      ncap = ncap + 1;
    end
  end

  function automatic bit read_live(int j);
    for (int i = j; i >= 0; i--) begin
      if (capcmd[i] == 2'b11) continue;
      return capcmd[i] == 2'b01;
    end
    return 1'b0;
  endfunction

  task automatic chk(string tag);
    int m = ncap - 1;
    bit ev;
    logic [W-1:0] ed;
    ed = '0;
    if (!rst_n) ev = 0;
    else if (!pipe_mode) begin
      ev = read_live(m);
      ed = arr_rdata;
    end else begin
      ev = (m >= 1) && read_live(m - 1);
      ed = (m >= 1) ? arrval[m-1] : '0;
    end
    compared++;
    if (dq_en !== (ev & ~oe_n)) begin
      mismatched++;
      $display("FAIL %s dq_en actual=%b expected=%b t=%0t", tag, dq_en, ev & ~oe_n, $time);
    end
    if (ev) begin
      compared++;
      if (dq_o !== ed) begin
        mismatched++;
        $display("FAIL %s dq_o actual=%h expected=%h t=%0t", tag, dq_o, ed, $time);
      end
    end
  endtask

  task automatic cyc(logic [1:0] c, logic oen, string tag);
    @(negedge clk);
    arr_rdata = {4'($urandom()), $urandom()};
    oe_n = oen;
    #1;
    chk(tag);
    cmd = c;
  endtask

  // R7: toggle the enable between edges, check with no clock
  task automatic oe_pulse();
    #0.2 oe_n = 1'b1;
    #0.2 chk("R7");
    oe_n = 1'b0;
    #0.2 chk("R7");
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    cmd = 2'b01;
    pipe_mode = mode;
    for (int i = 0; i < 3; i++) cyc(2'b01, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic directed(string rt);
    cyc(2'b01, 0, rt); cyc(2'b01, 0, rt); cyc(2'b01, 0, rt); cyc(2'b01, 0, rt);
    cyc(2'b11, 0, "R6"); cyc(2'b11, 0, "R6"); cyc(2'b00, 0, "R6");
    cyc(2'b00, 0, "R4"); cyc(2'b01, 0, "R4"); cyc(2'b00, 0, "R4");
    cyc(2'b11, 0, "R4"); cyc(2'b10, 0, "R4"); cyc(2'b10, 0, "R5");
    cyc(2'b01, 0, "R5"); cyc(2'b10, 0, "R5"); cyc(2'b11, 0, "R5");
    cyc(2'b01, 0, "R5"); cyc(2'b01, 1, rt); cyc(2'b01, 0, "R7");
    cyc(2'b01, 0, rt); oe_pulse();
    cyc(2'b00, 0, rt); cyc(2'b00, 0, rt);
  endtask

  task automatic random_run(string rt);
    for (int i = 0; i < 400; i++)
      cyc(2'($urandom()), ($urandom() % 5) == 0, rt);
    cyc(2'b00, 0, rt); cyc(2'b00, 0, rt);
  endtask

  initial begin
    do_reset(1'b0);
    directed("R2");
    random_run("R2");
    do_reset(1'b1);
    directed("R3");
    random_run("R3");
    do_reset(1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule